// File: doc/BRIEF.md
# Circular Reorder Window with Dataflow Issue

This block is the instruction window of an out-of-order core. Decoded and renamed instructions enter it in program order at the allocation pointer, and each receives its slot index as its destination tag. A slot keeps the opcode, two source fields with ready flags, the architectural destination, the result and an exception cause. When a source is not ready, its source field holds the producer's tag in its low bits. Each cycle the block sends at most one ready slot to a functional unit, choosing the oldest one relative to the commit pointer.

Functional units report completion with a tag, a result and a cause. The result goes into the tagged slot and is also broadcast to every waiting source field, which marks that field ready. Retirement happens only at the commit pointer and strictly in order, and it presents the destination and the result. If the completed head slot carries a nonzero cause, the block raises a flush and discards the whole window by moving the allocation pointer back to the commit pointer.

Top module: `rob_window`

## Requirements
- R1: After reset the window is empty: `alloc_ready` is 1, `alloc_tag` is 0, and `issue_valid`, `commit_valid` and `flush` are 0.
- R2: An instruction is accepted on a clock edge where `alloc_valid` and `alloc_ready` are both 1. Its tag is the value `alloc_tag` showed in that cycle, and `alloc_tag` then advances by one, wrapping from DEPTH-1 to 0.
- R3: Once DEPTH instructions are held, `alloc_ready` is 0, and `alloc_valid` has no effect on any slot until a slot retires.
- R4: A slot is issued only when it holds an instruction, has not yet issued, and both of its operands are ready. `issue_opa` and `issue_opb` carry the operand values. Each allocation issues at most once.
- R5: When several slots are eligible, one is issued per cycle, and it is the one oldest in program order counted from the commit pointer, including across the wrap point.
- R6: A completion whose `cmpl_tag` matches a waiting source tag (source flag 0, the tag in the low TAG_W bits of the source field) sets that operand to `cmpl_data`. The slot can then issue from the next cycle on.
- R7: A completion in the same cycle as the allocation of an instruction whose source waits on that tag makes the operand ready at allocation, with the value `cmpl_data`.
- R8: `commit_valid` is 1 in the cycles where the head slot has completed with cause 0, and it presents that slot's destination and result. A younger slot that has completed waits until every older slot has retired.
- R9: When the head slot has completed with a nonzero cause, `flush` is 1 for one cycle with that cause, `commit_valid` is 0, nothing issues, and every entry is discarded. The next allocation receives the head's index as its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Instruction offered for allocation |
| alloc_ready | output | 1 | Window can accept an instruction this cycle |
| alloc_tag | output | TAG_W | Tag the offered instruction receives |
| alloc_op | input | OP_W | Opcode |
| alloc_src1_rdy | input | 1 | Source 1 holds a value (1) or a producer tag (0) |
| alloc_src1 | input | DATA_W | Source 1 value or tag |
| alloc_src2_rdy | input | 1 | Source 2 holds a value (1) or a producer tag (0) |
| alloc_src2 | input | DATA_W | Source 2 value or tag |
| alloc_dest | input | DEST_W | Architectural destination register |
| issue_valid | output | 1 | A slot is sent to a functional unit this cycle |
| issue_tag | output | TAG_W | Tag of the issued slot |
| issue_op | output | OP_W | Opcode of the issued slot |
| issue_opa | output | DATA_W | First operand value |
| issue_opb | output | DATA_W | Second operand value |
| cmpl_valid | input | 1 | Completion broadcast present |
| cmpl_tag | input | TAG_W | Tag of the completing slot |
| cmpl_data | input | DATA_W | Result |
| cmpl_cause | input | CAUSE_W | Exception cause, 0 for none |
| commit_valid | output | 1 | Head slot retires this cycle |
| commit_dest | output | DEST_W | Destination of the retiring slot |
| commit_data | output | DATA_W | Result of the retiring slot |
| flush | output | 1 | Window discarded on a head exception |
| flush_cause | output | CAUSE_W | Cause of the flushing exception |

## Verification
A wrong ready flag or a missed broadcast leaves a slot that never issues. At the ports this shows up one cycle after the completion that should have woken it: `issue_valid` stays low, or a younger tag appears instead. A damaged pointer or a wrong count shows up at `alloc_tag` or `alloc_ready` on the next allocation. A slot overwritten by a stalled allocation appears as a wrong `commit_dest` when that slot retires. Flush errors are seen in the cycle after the flush, when the next tag must equal the head index and no stale slot may issue or commit.

// File: rtl/rob_pkg.sv
package rob_pkg;
    localparam int DEF_DEPTH   = 8;
    localparam int DEF_DATA_W  = 16;
    localparam int DEF_OP_W    = 4;
    localparam int DEF_DEST_W  = 5;
    localparam int DEF_CAUSE_W = 4;

    // action taken on the head slot in the current cycle
    typedef enum logic [1:0] {
        HEAD_WAIT   = 2'd0,
        HEAD_RETIRE = 2'd1,
        HEAD_FLUSH  = 2'd2
    } head_act_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
    parameter int DEPTH = rob_pkg::DEF_DEPTH,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic             retire_en,
    input  logic             flush_en,
    output logic [TAG_W-1:0] tail,
    output logic [TAG_W-1:0] head,
    output logic             full
);
    typedef struct packed {
        logic [TAG_W-1:0] tail;
        logic [TAG_W-1:0] head;
        logic [CNT_W-1:0] count;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    function automatic logic [TAG_W-1:0] wrap_inc(input logic [TAG_W-1:0] p);
        return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (flush_en) begin
            st_d.tail  = st_q.head;
            st_d.count = '0;
        end else begin
            if (alloc_en)  st_d.tail = wrap_inc(st_q.tail);
            if (retire_en) st_d.head = wrap_inc(st_q.head);
            st_d.count = st_q.count + CNT_W'(alloc_en) - CNT_W'(retire_en);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tail = st_q.tail;
    assign head = st_q.head;
    assign full = (st_q.count == CNT_W'(DEPTH));

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(DEPTH));

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_en |=> (st_q.count == '0 && st_q.tail == st_q.head));

    // R8
    retire_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_en && !flush_en) |=> st_q.head == wrap_inc($past(st_q.head)));
endmodule

// File: rtl/rob_pick.sv
module rob_pick #(
    parameter int DEPTH = rob_pkg::DEF_DEPTH,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] eligible,
    input  logic [TAG_W-1:0] oldest,
    output logic             grant_valid,
    output logic [TAG_W-1:0] grant_idx
);
    // scan from the commit pointer forward so age decides priority
    always_comb begin
        grant_valid = 1'b0;
        grant_idx   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (!grant_valid && eligible[(int'(oldest) + k) % DEPTH]) begin
                grant_valid = 1'b1;
                grant_idx   = TAG_W'((int'(oldest) + k) % DEPTH);
            end
        end
    end

    // R4
    grant_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> eligible[grant_idx]);
endmodule

// File: rtl/rob_window.sv
module rob_window #(
    parameter int DEPTH   = rob_pkg::DEF_DEPTH,
    parameter int DATA_W  = rob_pkg::DEF_DATA_W,
    parameter int OP_W    = rob_pkg::DEF_OP_W,
    parameter int DEST_W  = rob_pkg::DEF_DEST_W,
    parameter int CAUSE_W = rob_pkg::DEF_CAUSE_W,
    localparam int TAG_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_valid,
    output logic               alloc_ready,
    output logic [TAG_W-1:0]   alloc_tag,
    input  logic [OP_W-1:0]    alloc_op,
    input  logic               alloc_src1_rdy,
    input  logic [DATA_W-1:0]  alloc_src1,
    input  logic               alloc_src2_rdy,
    input  logic [DATA_W-1:0]  alloc_src2,
    input  logic [DEST_W-1:0]  alloc_dest,
    output logic               issue_valid,
    output logic [TAG_W-1:0]   issue_tag,
    output logic [OP_W-1:0]    issue_op,
    output logic [DATA_W-1:0]  issue_opa,
    output logic [DATA_W-1:0]  issue_opb,
    input  logic               cmpl_valid,
    input  logic [TAG_W-1:0]   cmpl_tag,
    input  logic [DATA_W-1:0]  cmpl_data,
    input  logic [CAUSE_W-1:0] cmpl_cause,
    output logic               commit_valid,
    output logic [DEST_W-1:0]  commit_dest,
    output logic [DATA_W-1:0]  commit_data,
    output logic               flush,
    output logic [CAUSE_W-1:0] flush_cause
);
    import rob_pkg::*;

    typedef struct packed {
        logic               used;
        logic               exec;
        logic               done;
        logic [OP_W-1:0]    op;
        logic               rdy1;
        logic [DATA_W-1:0]  src1;
        logic               rdy2;
        logic [DATA_W-1:0]  src2;
        logic [DEST_W-1:0]  dest;
        logic [DATA_W-1:0]  data;
        logic [CAUSE_W-1:0] cause;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
    } win_state_t;

    win_state_t st_d, st_q;

    logic [TAG_W-1:0] tail, head;
    logic             full;
    logic [DEPTH-1:0] eligible;
    logic             grant_valid;
    logic [TAG_W-1:0] grant_idx;
    head_act_e        head_act;
    slot_t            head_slot, pick_slot;
    logic             alloc_en, retire_en, flush_en, issue_en;
    logic             wake1, wake2;

    rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (alloc_en),
        .retire_en (retire_en),
        .flush_en  (flush_en),
        .tail      (tail),
        .head      (head),
        .full      (full)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_elig
        assign eligible[g] = st_q.slot[g].used && !st_q.slot[g].exec
                             && st_q.slot[g].rdy1 && st_q.slot[g].rdy2;
    end

    rob_pick #(.DEPTH(DEPTH)) u_pick (
        .clk         (clk),
        .rst_n       (rst_n),
        .eligible    (eligible),
        .oldest      (head),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx)
    );

    always_comb begin
        head_slot = st_q.slot[head];
        pick_slot = st_q.slot[grant_idx];
        head_act  = HEAD_WAIT;
        if (head_slot.used && head_slot.done)
            head_act = (head_slot.cause != '0) ? HEAD_FLUSH : HEAD_RETIRE;

        flush_en    = (head_act == HEAD_FLUSH);
        retire_en   = (head_act == HEAD_RETIRE);
        alloc_ready = !full && !flush_en;
        alloc_en    = alloc_valid && alloc_ready;
        issue_en    = grant_valid && !flush_en;

        wake1 = !alloc_src1_rdy && cmpl_valid && (cmpl_tag == alloc_src1[TAG_W-1:0]);
        wake2 = !alloc_src2_rdy && cmpl_valid && (cmpl_tag == alloc_src2[TAG_W-1:0]);

        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            // result broadcast wakes waiting sources
            if (cmpl_valid && st_q.slot[i].used) begin
                if (!st_q.slot[i].rdy1 && st_q.slot[i].src1[TAG_W-1:0] == cmpl_tag) begin
                    st_d.slot[i].rdy1 = 1'b1;
                    st_d.slot[i].src1 = cmpl_data;
                end
                if (!st_q.slot[i].rdy2 && st_q.slot[i].src2[TAG_W-1:0] == cmpl_tag) begin
                    st_d.slot[i].rdy2 = 1'b1;
                    st_d.slot[i].src2 = cmpl_data;
                end
                if (cmpl_tag == TAG_W'(i)) begin
                    st_d.slot[i].done  = 1'b1;
                    st_d.slot[i].data  = cmpl_data;
                    st_d.slot[i].cause = cmpl_cause;
                end
            end
            if (issue_en && grant_idx == TAG_W'(i))
                st_d.slot[i].exec = 1'b1;
            if (retire_en && head == TAG_W'(i))
                st_d.slot[i].used = 1'b0;
            if (alloc_en && tail == TAG_W'(i)) begin
                st_d.slot[i].used  = 1'b1;
                st_d.slot[i].exec  = 1'b0;
                st_d.slot[i].done  = 1'b0;
                st_d.slot[i].op    = alloc_op;
                st_d.slot[i].rdy1  = alloc_src1_rdy || wake1;
                st_d.slot[i].src1  = wake1 ? cmpl_data : alloc_src1;
                st_d.slot[i].rdy2  = alloc_src2_rdy || wake2;
                st_d.slot[i].src2  = wake2 ? cmpl_data : alloc_src2;
                st_d.slot[i].dest  = alloc_dest;
                st_d.slot[i].data  = '0;
                st_d.slot[i].cause = '0;
            end
            if (flush_en)
                st_d.slot[i].used = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alloc_tag    = tail;
    assign issue_valid  = issue_en;
    assign issue_tag    = grant_idx;
    assign issue_op     = pick_slot.op;
    assign issue_opa    = pick_slot.src1;
    assign issue_opb    = pick_slot.src2;
    assign commit_valid = retire_en;
    assign commit_dest  = head_slot.dest;
    assign commit_data  = head_slot.data;
    assign flush        = flush_en;
    assign flush_cause  = head_slot.cause;

    // R4
    no_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> !(issue_valid && issue_tag == $past(issue_tag)));

    // R9
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!commit_valid && !issue_valid && alloc_ready));
endmodule

// File: tb/tb_rob_window.sv
module tb_rob_window;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        alloc_valid;
    logic        alloc_ready;
    logic [2:0]  alloc_tag;
    logic [3:0]  alloc_op;
    logic        alloc_src1_rdy;
    logic [15:0] alloc_src1;
    logic        alloc_src2_rdy;
    logic [15:0] alloc_src2;
    logic [4:0]  alloc_dest;
    logic        issue_valid;
    logic [2:0]  issue_tag;
    logic [3:0]  issue_op;
    logic [15:0] issue_opa, issue_opb;
    logic        cmpl_valid;
    logic [2:0]  cmpl_tag;
    logic [15:0] cmpl_data;
    logic [3:0]  cmpl_cause;
    logic        commit_valid;
    logic [4:0]  commit_dest;
    logic [15:0] commit_data;
    logic        flush;
    logic [3:0]  flush_cause;

    int checks = 0;
    int failures = 0;
    bit reported = 0;

    always #4 clk = ~clk;

    rob_window dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .alloc_op(alloc_op), .alloc_src1_rdy(alloc_src1_rdy), .alloc_src1(alloc_src1),
        .alloc_src2_rdy(alloc_src2_rdy), .alloc_src2(alloc_src2), .alloc_dest(alloc_dest),
        .issue_valid(issue_valid), .issue_tag(issue_tag), .issue_op(issue_op),
        .issue_opa(issue_opa), .issue_opb(issue_opb),
        .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag), .cmpl_data(cmpl_data),
        .cmpl_cause(cmpl_cause),
        .commit_valid(commit_valid), .commit_dest(commit_dest), .commit_data(commit_data),
        .flush(flush), .flush_cause(flush_cause)
    );

    typedef struct packed {
        logic        av;
        logic [3:0]  op;
        logic        r1;
        logic [15:0] s1;
        logic        r2;
        logic [15:0] s2;
        logic [4:0]  dest;
        logic        cv;
        logic [2:0]  ctag;
        logic [15:0] cdata;
        logic [3:0]  ccause;
        logic        eiv;
        logic [2:0]  eitag;
        logic [15:0] eia;
        logic [15:0] eib;
        logic        ecv;
        logic [4:0]  ecdest;
        logic [15:0] ecdata;
        logic [2:0]  eatag;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1,1,1,5,1,7,1,    0,0,0,0,   0,0,0,0,   0,0,0,  0},
        '{1,2,0,0,1,1,2,    0,0,0,0,   1,0,5,7,   0,0,0,  1},
        '{1,3,1,3,1,4,3,    0,0,0,0,   0,0,0,0,   0,0,0,  2},
        '{0,0,0,0,0,0,0,    1,0,12,0,  1,2,3,4,   0,0,0,  3},
        '{0,0,0,0,0,0,0,    0,0,0,0,   1,1,12,1,  1,1,12, 3},
        '{0,0,0,0,0,0,0,    1,2,7,0,   0,0,0,0,   0,0,0,  3},
        '{0,0,0,0,0,0,0,    1,1,13,0,  0,0,0,0,   0,0,0,  3},
        '{0,0,0,0,0,0,0,    0,0,0,0,   0,0,0,0,   1,2,13, 3},
        '{0,0,0,0,0,0,0,    0,0,0,0,   0,0,0,0,   1,3,7,  3},
        '{0,0,0,0,0,0,0,    0,0,0,0,   0,0,0,0,   0,0,0,  3}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        alloc_valid = 0; alloc_op = 0; alloc_src1_rdy = 0; alloc_src1 = 0;
        alloc_src2_rdy = 0; alloc_src2 = 0; alloc_dest = 0;
        cmpl_valid = 0; cmpl_tag = 0; cmpl_data = 0; cmpl_cause = 0;
    endtask

    task automatic drv_alloc(input logic [3:0] op, input logic r1, input logic [15:0] s1,
                             input logic r2, input logic [15:0] s2, input logic [4:0] d);
        alloc_valid = 1; alloc_op = op; alloc_src1_rdy = r1; alloc_src1 = s1;
        alloc_src2_rdy = r2; alloc_src2 = s2; alloc_dest = d;
    endtask

    task automatic drv_cmpl(input logic [2:0] t, input logic [15:0] d, input logic [3:0] c);
        cmpl_valid = 1; cmpl_tag = t; cmpl_data = d; cmpl_cause = c;
    endtask

    // inputs change just after a rising edge; outputs are read at the falling edge
    task automatic next_cycle();
        @(posedge clk);
        #1;
        idle_inputs();
    endtask

    task automatic sample();
        @(negedge clk);
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        sample();
        chk("R1 alloc_ready", alloc_ready, 1);
        chk("R1 alloc_tag", alloc_tag, 0);
        chk("R1 issue_valid", issue_valid, 0);
        chk("R1 commit_valid", commit_valid, 0);
        chk("R1 flush", flush, 0);

        // table walk: allocation, wakeup, oldest issue, in-order commit
        foreach (VECS[v]) begin
            next_cycle();
            if (VECS[v].av) drv_alloc(VECS[v].op, VECS[v].r1, VECS[v].s1,
                                      VECS[v].r2, VECS[v].s2, VECS[v].dest);
            if (VECS[v].cv) drv_cmpl(VECS[v].ctag, VECS[v].cdata, VECS[v].ccause);
            sample();
            chk("R2 alloc_tag", alloc_tag, VECS[v].eatag);
            chk("R4 R6 issue_valid", issue_valid, VECS[v].eiv);
            if (VECS[v].eiv) begin
                chk("R5 issue_tag", issue_tag, VECS[v].eitag);
                chk("R4 issue_opa", issue_opa, VECS[v].eia);
                chk("R4 issue_opb", issue_opb, VECS[v].eib);
            end
            chk("R8 commit_valid", commit_valid, VECS[v].ecv);
            if (VECS[v].ecv) begin
                chk("R8 commit_dest", commit_dest, VECS[v].ecdest);
                chk("R8 commit_data", commit_data, VECS[v].ecdata);
            end
        end

        // R7: completion in the same cycle as an allocation waiting on its tag
        next_cycle();
        drv_alloc(2, 0, 0, 1, 2, 4);
        drv_cmpl(0, 21, 0);
        sample();
        chk("R2 alloc_tag", alloc_tag, 3);
        next_cycle();
        sample();
        chk("R7 issue_valid", issue_valid, 1);
        chk("R7 issue_tag", issue_tag, 3);
        chk("R7 issue_opa", issue_opa, 21);
        next_cycle();
        drv_cmpl(3, 5, 0);
        next_cycle();
        sample();
        chk("R8 commit_valid", commit_valid, 1);
        chk("R8 commit_dest", commit_dest, 4);

        // R5: oldest-first selection across the wrap point (head 4)
        next_cycle();
        drv_alloc(3, 1, 10, 1, 20, 5);
        next_cycle();
        drv_alloc(1, 0, 4, 1, 1, 6);
        sample();
        chk("R4 issue_tag", issue_tag, 4);
        chk("R4 issue_valid", issue_valid, 1);
        next_cycle();
        drv_alloc(1, 0, 4, 1, 1, 7);
        next_cycle();
        drv_alloc(1, 0, 4, 1, 1, 8);
        next_cycle();
        drv_alloc(1, 0, 4, 1, 1, 9);
        sample();
        chk("R2 alloc_tag wrap", alloc_tag, 0);
        next_cycle();
        drv_cmpl(4, 50, 0);
        sample();
        chk("R6 waiting not issued", issue_valid, 0);
        next_cycle();
        sample();
        chk("R5 oldest 1st", issue_tag, 5);
        chk("R6 issue_opa", issue_opa, 50);
        chk("R8 commit_data", commit_data, 50);
        next_cycle();
        sample();
        chk("R5 oldest 2nd", issue_tag, 6);
        chk("R8 no early commit", commit_valid, 0);
        next_cycle();
        sample();
        chk("R5 oldest 3rd", issue_tag, 7);
        next_cycle();
        sample();
        chk("R5 wrapped youngest", issue_tag, 0);
        next_cycle();
        sample();
        chk("R4 no reissue", issue_valid, 0);

        // R9: exception on the youngest entry, reported out of order
        next_cycle();
        drv_cmpl(0, 0, 3);
        drv_alloc(4, 0, 2, 1, 0, 10);
        sample();
        chk("R2 alloc_tag", alloc_tag, 1);
        for (int t = 5; t < 8; t++) begin
            next_cycle();
            drv_cmpl(3'(t), 16'(60 + t), 0);
            sample();
            chk("R9 no flush before head", flush, 0);
            next_cycle();
            sample();
            chk("R8 commit_valid", commit_valid, 1);
            chk("R8 commit_dest", commit_dest, t + 1);
            chk("R8 commit_data", commit_data, 60 + t);
        end
        next_cycle();
        sample();
        chk("R9 flush", flush, 1);
        chk("R9 flush_cause", flush_cause, 3);
        chk("R9 no commit", commit_valid, 0);
        chk("R9 alloc_ready", alloc_ready, 0);
        next_cycle();
        sample();
        chk("R9 flush pulse", flush, 0);
        chk("R9 tag reset to head", alloc_tag, 0);
        chk("R9 no stale issue", issue_valid, 0);
        chk("R9 no stale commit", commit_valid, 0);

        // R3: fill the window, stall, then free one slot
        for (int i = 0; i < 8; i++) begin
            next_cycle();
            drv_alloc(1, 1, 1, 1, 1, 5'(i));
            sample();
            chk("R3 ready before full", alloc_ready, 1);
            chk("R2 alloc_tag", alloc_tag, i);
        end
        next_cycle();
        drv_alloc(1, 1, 1, 1, 1, 15);
        sample();
        chk("R3 full", alloc_ready, 0);
        next_cycle();
        drv_cmpl(0, 77, 0);
        next_cycle();
        sample();
        chk("R3 commit_valid", commit_valid, 1);
        chk("R3 stalled alloc ignored", commit_dest, 0);
        chk("R8 commit_data", commit_data, 77);
        next_cycle();
        sample();
        chk("R3 ready after retire", alloc_ready, 1);
        chk("R2 alloc_tag", alloc_tag, 0);
        drv_cmpl(1, 88, 0);
        next_cycle();
        sample();
        chk("R8 commit_dest", commit_dest, 1);
        chk("R8 commit_data", commit_data, 88);

        report();
        $finish;
    end
endmodule